// File: doc/BRIEF.md
# Endpoint Interrupt and Control Register Bank

This block keeps the per-endpoint register state of a small USB device controller that has five endpoints. For each endpoint it stores an enable and stall-request control word, two configuration words, a status word, an interrupt-enable word and an interrupt-flag word. A CPU port reaches one endpoint at a time. An endpoint-select register picks the endpoint, and that same port also reads the summary vector. The transfer engine on the host side reports events through a single event strobe: a SETUP packet received, OUT data received, an IN bank taken by the host, a FIFO overflow and a FIFO underflow. It also reports each host access, so that the block can answer with a stall for an endpoint that has a pending stall request.

Each event sets a flag and marks its endpoint in a summary vector. One shared interrupt request is asserted as a level whenever any endpoint holds a flag whose enable bit is set. Software can only clear flags, and it does so by writing zeros. Software clears a summary bit by writing the flag word so that no flag other than the read/write-allowed bit remains. The read/write-allowed bit is not stored. It is computed on every read from the state of the selected endpoint's FIFO and from the endpoint direction.

Top module: `ep_irq_regs`

## Requirements
- R1: The CPU register addresses are: 0 endpoint select, 1 control, 2 config 0, 3 config 1, 4 status, 5 interrupt enable, 6 interrupt flags and 7 summary (read only). Writes to addresses 1 to 6 and reads from addresses 1 to 6 reach the selected endpoint. Writing a select value of 5 or more is ignored and the previous selection is kept.
- R2: An event pulse (`ev_valid`) with kind 0 (SETUP) sets flag bit 3, kind 1 (OUT) sets flag bit 2 and kind 2 (IN taken) sets flag bit 0 on endpoint `ev_ep`. Every event, including kinds 3 and 4, sets bit `ev_ep` of `ep_summary` one cycle later.
- R3: Event kind 3 (overflow) sets status bit 6 and event kind 4 (underflow) sets status bit 5. Both are gated into the interrupt request by enable bit 4. A status write keeps each of these two bits only where the written bit is 1.
- R4: A write to the flag word can only clear bits. Each stored flag (bits 7, 3, 2, 1 and 0) becomes 0 where the written bit is 0 and is unchanged where the written bit is 1.
- R5: After a flag write, if every flag bit other than bit 5 is zero, the selected endpoint's summary bit is cleared. An event in the same cycle takes priority.
- R6: A flag write that clears the SETUP flag (bit 3) also clears the OUT flag (bit 2).
- R7: When the flag word is read, bit 5 equals NOT `sel_fifo_full` for an IN endpoint (config 0 bit 0 = 1) and NOT `sel_fifo_empty` for an OUT endpoint.
- R8: A write to config 0 clears config-ok (status bit 7). A write to config 1 sets config-ok to the written bit 1.
- R9: A config 1 write on an endpoint with a non-zero type (config 0 bits 7:6) and the IN direction sets TX-ready (flag bit 0) and FIFO-control (flag bit 7), and clears the OUT flag.
- R10: A config 1 write on a control endpoint (type 0) sets TX-ready and clears the OUT flag.
- R11: Control bit 0 is the endpoint enable and is written directly. Writing control bit 4 clears the stall request, and writing bit 5 sets it (bit 5 wins if both are written). The stall request reads back as bit 5.
- R12: A host access (`host_acc_valid`) to an endpoint whose stall request is set asserts `host_stall` in the same cycle. One cycle later it sets the stalled flag (bit 1) of endpoint 0 and summary bit 0.
- R13: `ep_irq` is high exactly when some endpoint has a flag among bits 3:0 with the matching enable bit set, or has an overflow or underflow status bit with enable bit 4 set.
- R14: After reset all endpoint registers, the selection, `ep_summary` and `ep_irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 3 | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data for `cpu_addr` (combinational) |
| sel_fifo_full | input | 1 | FIFO of the selected endpoint is full |
| sel_fifo_empty | input | 1 | FIFO of the selected endpoint is empty |
| ev_valid | input | 1 | Endpoint event strobe |
| ev_ep | input | EPW | Endpoint of the event |
| ev_kind | input | 3 | Event kind (0 setup, 1 out, 2 in-taken, 3 overflow, 4 underflow) |
| host_acc_valid | input | 1 | Host access strobe |
| host_acc_ep | input | EPW | Endpoint the host accesses |
| host_stall | output | 1 | Answer the host access with STALL |
| ep_summary | output | NUM_EP | Per-endpoint pending-event vector |
| ep_irq | output | 1 | Shared endpoint interrupt request |

## Verification
The bench checks the flag word against writes of all ones and of partial zero patterns. A design that let a written 1 set a flag, or that ignored a written 0, would return the wrong flag value. It checks that clearing SETUP also drops a pending OUT flag while a 1 is written to the OUT bit; a design without that coupling would leave bit 2 set. It checks that the summary bit falls only after the last flag other than read/write-allowed is gone, and that an out-of-range select write is ignored. It also moves the FIFO inputs on IN and OUT endpoints to expose a read/write-allowed bit tied to the wrong FIFO condition, checks that the config 1 presets depend on type and direction, and checks that the interrupt stays low while the enables are zero even though the flags are set.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
  localparam int EP_CNT = 5;
  localparam int RW = 8;

  // CPU register map
  localparam logic [2:0] A_SEL   = 3'd0;
  localparam logic [2:0] A_CTRL  = 3'd1;
  localparam logic [2:0] A_CFG0  = 3'd2;
  localparam logic [2:0] A_CFG1  = 3'd3;
  localparam logic [2:0] A_STAT  = 3'd4;
  localparam logic [2:0] A_IEN   = 3'd5;
  localparam logic [2:0] A_FLAGS = 3'd6;
  localparam logic [2:0] A_SUMM  = 3'd7;

  // flag bit positions
  localparam int F_TXRDY = 0;
  localparam int F_STALL = 1;
  localparam int F_OUT   = 2;
  localparam int F_SETUP = 3;
  localparam int F_RWAL  = 5;
  localparam int F_FCON  = 7;
  localparam logic [7:0] FLAG_STORE = 8'h8F;

  // status / control bit positions
  localparam int S_CFGOK = 7;
  localparam int S_OVF   = 6;
  localparam int S_UNF   = 5;
  localparam int C_EN    = 0;
  localparam int C_STCLR = 4;
  localparam int C_STREQ = 5;
  localparam int E_FLERR = 4;

  typedef enum logic [2:0] {
    EV_SETUP  = 3'd0,
    EV_OUT    = 3'd1,
    EV_INTAKE = 3'd2,
    EV_OVF    = 3'd3,
    EV_UNF    = 3'd4
  } ev_kind_e;
endpackage

// File: rtl/ep_slot.sv
module ep_slot
  import ep_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [RW-1:0] wr_data,
  input  logic [RW-1:0] ev_flag_set,
  input  logic          ev_ovf,
  input  logic          ev_unf,
  output logic [RW-1:0] ctrl_o,
  output logic [RW-1:0] cfg0_o,
  output logic [RW-1:0] cfg1_o,
  output logic [RW-1:0] stat_o,
  output logic [RW-1:0] ien_o,
  output logic [RW-1:0] flags_o,
  output logic          summ_o,
  output logic          irq_o
);
  logic [RW-1:0] ctrl_q, cfg0_q, cfg1_q, stat_q, ien_q, flags_q;
  logic [RW-1:0] ctrl_d, cfg0_d, cfg1_d, stat_d, ien_d, flags_d;
  logic          summ_q, summ_d, summ_clr, ev_any, upd;

  assign ev_any = (|ev_flag_set) | ev_ovf | ev_unf;
  assign upd    = wr_en | ev_any;

  always_comb begin
    ctrl_d   = ctrl_q;
    cfg0_d   = cfg0_q;
    cfg1_d   = cfg1_q;
    stat_d   = stat_q;
    ien_d    = ien_q;
    flags_d  = flags_q;
    summ_clr = 1'b0;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin  // R11
          ctrl_d[C_EN] = wr_data[C_EN];
          if (wr_data[C_STCLR]) ctrl_d[C_STREQ] = 1'b0;
          if (wr_data[C_STREQ]) ctrl_d[C_STREQ] = 1'b1;
        end
        A_CFG0: begin  // R8
          cfg0_d          = wr_data;
          stat_d[S_CFGOK] = 1'b0;
        end
        A_CFG1: begin  // R8, R9, R10
          cfg1_d          = wr_data;
          stat_d[S_CFGOK] = wr_data[1];
          if (cfg0_q[7:6] == 2'b00) begin
            flags_d[F_TXRDY] = 1'b1;
          end else if (cfg0_q[0]) begin
            flags_d[F_TXRDY] = 1'b1;
            flags_d[F_FCON]  = 1'b1;
          end
          flags_d[F_OUT] = 1'b0;
        end
        A_STAT:  stat_d[S_OVF:S_UNF] = stat_q[S_OVF:S_UNF] & wr_data[S_OVF:S_UNF];  // R3
        A_IEN:   ien_d = wr_data;
        A_FLAGS: begin  // R4, R6, R5
          flags_d = flags_q & wr_data & FLAG_STORE;
          if (flags_q[F_SETUP] && !wr_data[F_SETUP]) flags_d[F_OUT] = 1'b0;
          summ_clr = ((flags_d & ~(RW'(1) << F_RWAL)) == '0);
        end
        default: ;
      endcase
    end
    flags_d       = flags_d | ev_flag_set;  // R2: events win over clears
    stat_d[S_OVF] = stat_d[S_OVF] | ev_ovf;
    stat_d[S_UNF] = stat_d[S_UNF] | ev_unf;
    summ_d        = (summ_q & ~summ_clr) | ev_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin  // R14
      ctrl_q  <= '0;
      cfg0_q  <= '0;
      cfg1_q  <= '0;
      stat_q  <= '0;
      ien_q   <= '0;
      flags_q <= '0;
      summ_q  <= 1'b0;
    end else if (upd) begin
      ctrl_q  <= ctrl_d;
      cfg0_q  <= cfg0_d;
      cfg1_q  <= cfg1_d;
      stat_q  <= stat_d;
      ien_q   <= ien_d;
      flags_q <= flags_d;
      summ_q  <= summ_d;
    end
  end

  // R13: level request from enabled flags and flow errors
  assign irq_o = (|(ien_q[3:0] & flags_q[3:0])) |
                 (ien_q[E_FLERR] & (stat_q[S_OVF] | stat_q[S_UNF]));

  assign ctrl_o  = ctrl_q;
  assign cfg0_o  = cfg0_q;
  assign cfg1_o  = cfg1_q;
  assign stat_o  = stat_q;
  assign ien_o   = ien_q;
  assign flags_o = flags_q;
  assign summ_o  = summ_q;
endmodule

// File: rtl/ep_rd_mux.sv
module ep_rd_mux
  import ep_irq_pkg::*;
#(
  parameter  int NUM_EP = EP_CNT,
  localparam int EPW    = $clog2(NUM_EP)
) (
  input  logic [2:0]           addr,
  input  logic [EPW-1:0]       sel,
  input  logic [NUM_EP*RW-1:0] ctrl_flat,
  input  logic [NUM_EP*RW-1:0] cfg0_flat,
  input  logic [NUM_EP*RW-1:0] cfg1_flat,
  input  logic [NUM_EP*RW-1:0] stat_flat,
  input  logic [NUM_EP*RW-1:0] ien_flat,
  input  logic [NUM_EP*RW-1:0] flags_flat,
  input  logic [NUM_EP-1:0]    summary,
  input  logic                 fifo_full,
  input  logic                 fifo_empty,
  output logic [RW-1:0]        rdata
);
  logic [RW-1:0] cfg0_s, flags_s;
  logic          rwal;

  assign cfg0_s  = cfg0_flat[sel*RW +: RW];
  assign flags_s = flags_flat[sel*RW +: RW];
  // R7: read/write-allowed is derived live
  assign rwal    = cfg0_s[0] ? ~fifo_full : ~fifo_empty;

  always_comb begin
    case (addr)
      A_SEL:   rdata = RW'(sel);
      A_CTRL:  rdata = ctrl_flat[sel*RW +: RW];
      A_CFG0:  rdata = cfg0_s;
      A_CFG1:  rdata = cfg1_flat[sel*RW +: RW];
      A_STAT:  rdata = stat_flat[sel*RW +: RW];
      A_IEN:   rdata = ien_flat[sel*RW +: RW];
      A_FLAGS: rdata = flags_s | (RW'(rwal) << F_RWAL);
      default: rdata = RW'(summary);
    endcase
  end
endmodule

// File: rtl/ep_irq_regs.sv
module ep_irq_regs
  import ep_irq_pkg::*;
#(
  parameter  int NUM_EP = EP_CNT,
  localparam int EPW    = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [2:0]        cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              sel_fifo_full,
  input  logic              sel_fifo_empty,
  input  logic              ev_valid,
  input  logic [EPW-1:0]    ev_ep,
  input  logic [2:0]        ev_kind,
  input  logic              host_acc_valid,
  input  logic [EPW-1:0]    host_acc_ep,
  output logic              host_stall,
  output logic [NUM_EP-1:0] ep_summary,
  output logic              ep_irq
);
  logic [EPW-1:0]       sel_q, sel_d;
  logic                 sel_ld;
  logic [NUM_EP*RW-1:0] ctrl_flat, cfg0_flat, cfg1_flat, stat_flat, ien_flat, flags_flat;
  logic [NUM_EP-1:0]    irq_vec;

  // R1: endpoint select, out-of-range values dropped
  assign sel_ld = cpu_we && (cpu_addr == A_SEL) && (32'(cpu_wdata) < NUM_EP);
  assign sel_d  = cpu_wdata[EPW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_ld) sel_q <= sel_d;
  end

  // R12: stall answer to host access
  assign host_stall = host_acc_valid && (32'(host_acc_ep) < NUM_EP) &&
                      ctrl_flat[32'(host_acc_ep)*RW + C_STREQ];

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic          hit;
    logic [RW-1:0] fset;

    assign hit = ev_valid && (ev_ep == EPW'(i));

    always_comb begin
      fset = '0;
      if (hit) begin
        case (ev_kind)
          EV_SETUP:  fset[F_SETUP] = 1'b1;
          EV_OUT:    fset[F_OUT]   = 1'b1;
          EV_INTAKE: fset[F_TXRDY] = 1'b1;
          default:   ;
        endcase
      end
      if (i == 0 && host_stall) fset[F_STALL] = 1'b1;
    end

    ep_slot u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (cpu_we && (sel_q == EPW'(i))),
      .wr_addr     (cpu_addr),
      .wr_data     (cpu_wdata),
      .ev_flag_set (fset),
      .ev_ovf      (hit && (ev_kind == EV_OVF)),
      .ev_unf      (hit && (ev_kind == EV_UNF)),
      .ctrl_o      (ctrl_flat[i*RW +: RW]),
      .cfg0_o      (cfg0_flat[i*RW +: RW]),
      .cfg1_o      (cfg1_flat[i*RW +: RW]),
      .stat_o      (stat_flat[i*RW +: RW]),
      .ien_o       (ien_flat[i*RW +: RW]),
      .flags_o     (flags_flat[i*RW +: RW]),
      .summ_o      (ep_summary[i]),
      .irq_o       (irq_vec[i])
    );
  end

  assign ep_irq = |irq_vec;

  ep_rd_mux #(.NUM_EP(NUM_EP)) u_mux (
    .addr       (cpu_addr),
    .sel        (sel_q),
    .ctrl_flat  (ctrl_flat),
    .cfg0_flat  (cfg0_flat),
    .cfg1_flat  (cfg1_flat),
    .stat_flat  (stat_flat),
    .ien_flat   (ien_flat),
    .flags_flat (flags_flat),
    .summary    (ep_summary),
    .fifo_full  (sel_fifo_full),
    .fifo_empty (sel_fifo_empty),
    .rdata      (cpu_rdata)
  );
endmodule

// File: rtl/ep_irq_chk.sv
module ep_irq_chk
  import ep_irq_pkg::*;
#(
  parameter  int NUM_EP = EP_CNT,
  localparam int EPW    = $clog2(NUM_EP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_we,
  input  logic [2:0]           cpu_addr,
  input  logic [7:0]           cpu_wdata,
  input  logic                 ev_valid,
  input  logic [EPW-1:0]       ev_ep,
  input  logic                 host_acc_valid,
  input  logic                 host_stall,
  input  logic [NUM_EP-1:0]    ep_summary,
  input  logic [EPW-1:0]       sel_q,
  input  logic [NUM_EP*RW-1:0] flags_flat
);
  logic [RW-1:0] sel_flags;
  assign sel_flags = flags_flat[sel_q*RW +: RW];

  // R1
  a_r1_sel_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == A_SEL && 32'(cpu_wdata) >= NUM_EP) |=> $stable(sel_q));

  // R2
  a_r2_summary_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && 32'(ev_ep) < NUM_EP) |=> ep_summary[$past(ev_ep)]);

  // R4
  a_r4_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == A_FLAGS && !ev_valid && !host_acc_valid)
      |=> ((sel_flags & ~$past(sel_flags)) == '0));

  // R6
  a_r6_setup_drops_out: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == A_FLAGS && !cpu_wdata[F_SETUP] && sel_flags[F_SETUP] && !ev_valid)
      |=> !sel_flags[F_OUT]);

  // R12
  a_r12_stall_flag: assert property (@(posedge clk) disable iff (!rst_n)
    host_stall |=> (flags_flat[F_STALL] && ep_summary[0]));
endmodule

bind ep_irq_regs ep_irq_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cpu_we         (cpu_we),
  .cpu_addr       (cpu_addr),
  .cpu_wdata      (cpu_wdata),
  .ev_valid       (ev_valid),
  .ev_ep          (ev_ep),
  .host_acc_valid (host_acc_valid),
  .host_stall     (host_stall),
  .ep_summary     (ep_summary),
  .sel_q          (sel_q),
  .flags_flat     (flags_flat)
);

// File: tb/test_ep_irq_regs.sv
module test_ep_irq_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EP = 5;

  typedef struct packed {
    logic [1:0] op;   // 0 write, 1 check read, 2 event
    logic [2:0] a;
    logic [7:0] d;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 46;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 3'd7, 8'h00, 4'd14},
    '{2'd0, 3'd0, 8'h01, 4'd1}, '{2'd1, 3'd0, 8'h01, 4'd1},
    '{2'd0, 3'd0, 8'h05, 4'd1}, '{2'd1, 3'd0, 8'h01, 4'd1},
    '{2'd0, 3'd2, 8'h81, 4'd9}, '{2'd0, 3'd3, 8'h02, 4'd9},
    '{2'd1, 3'd4, 8'h80, 4'd8}, '{2'd1, 3'd6, 8'hA1, 4'd9},
    '{2'd1, 3'd3, 8'h02, 4'd9},
    '{2'd0, 3'd2, 8'h81, 4'd8}, '{2'd1, 3'd4, 8'h00, 4'd8},
    '{2'd0, 3'd6, 8'hFE, 4'd4}, '{2'd1, 3'd6, 8'hA0, 4'd4},
    '{2'd2, 3'd1, 8'h01, 4'd2}, '{2'd1, 3'd7, 8'h02, 4'd2},
    '{2'd1, 3'd6, 8'hA4, 4'd2},
    '{2'd0, 3'd6, 8'hFF, 4'd4}, '{2'd1, 3'd6, 8'hA4, 4'd4},
    '{2'd1, 3'd7, 8'h02, 4'd5},
    '{2'd0, 3'd6, 8'h7B, 4'd5}, '{2'd1, 3'd6, 8'h20, 4'd5},
    '{2'd1, 3'd7, 8'h00, 4'd5},
    '{2'd0, 3'd0, 8'h00, 4'd1}, '{2'd2, 3'd0, 8'h00, 4'd2},
    '{2'd2, 3'd0, 8'h01, 4'd2}, '{2'd1, 3'd6, 8'h0C, 4'd2},
    '{2'd1, 3'd7, 8'h01, 4'd2},
    '{2'd0, 3'd6, 8'hF7, 4'd6}, '{2'd1, 3'd6, 8'h00, 4'd6},
    '{2'd1, 3'd7, 8'h00, 4'd5},
    '{2'd2, 3'd0, 8'h01, 4'd2}, '{2'd0, 3'd3, 8'h00, 4'd10},
    '{2'd1, 3'd6, 8'h01, 4'd10}, '{2'd1, 3'd4, 8'h00, 4'd8},
    '{2'd0, 3'd1, 8'h21, 4'd11}, '{2'd1, 3'd1, 8'h21, 4'd11},
    '{2'd0, 3'd1, 8'h11, 4'd11}, '{2'd1, 3'd1, 8'h01, 4'd11},
    '{2'd2, 3'd0, 8'h03, 4'd3}, '{2'd1, 3'd4, 8'h40, 4'd3},
    '{2'd2, 3'd0, 8'h04, 4'd3}, '{2'd1, 3'd4, 8'h60, 4'd3},
    '{2'd0, 3'd4, 8'h20, 4'd3}, '{2'd1, 3'd4, 8'h20, 4'd3},
    '{2'd1, 3'd1, 8'h01, 4'd11}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_we;
  logic [2:0] cpu_addr;
  logic [7:0] cpu_wdata;
  logic [7:0] cpu_rdata;
  logic       sel_fifo_full, sel_fifo_empty;
  logic       ev_valid;
  logic [2:0] ev_ep;
  logic [2:0] ev_kind;
  logic       host_acc_valid;
  logic [2:0] host_acc_ep;
  logic       host_stall;
  logic [NUM_EP-1:0] ep_summary;
  logic       ep_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_irq_regs #(.NUM_EP(NUM_EP)) i_ep_irq_regs (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .sel_fifo_full(sel_fifo_full), .sel_fifo_empty(sel_fifo_empty),
    .ev_valid(ev_valid), .ev_ep(ev_ep), .ev_kind(ev_kind),
    .host_acc_valid(host_acc_valid), .host_acc_ep(host_acc_ep),
    .host_stall(host_stall), .ep_summary(ep_summary), .ep_irq(ep_irq)
  );

  task automatic check(input int rq, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %02h expected %02h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd_chk(input int rq, input logic [2:0] a, input logic [7:0] exp);
    cpu_addr = a;
    #1;
    check(rq, $sformatf("read addr %0d", a), cpu_rdata, exp);
  endtask

  task automatic ev(input logic [2:0] ep, input logic [2:0] kind);
    @(negedge clk);
    ev_valid = 1'b1; ev_ep = ep; ev_kind = kind;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cpu_we = 1'b0; cpu_addr = 3'd0; cpu_wdata = 8'h00;
    sel_fifo_full = 1'b0; sel_fifo_empty = 1'b1;
    ev_valid = 1'b0; ev_ep = 3'd0; ev_kind = 3'd0;
    host_acc_valid = 1'b0; host_acc_ep = 3'd0;
    do_reset();

    // table walk covering R1..R11 and R14
    for (int k = 0; k < NV; k++) begin
      case (TBL[k].op)
        2'd0: wr(TBL[k].a, TBL[k].d);
        2'd1: rd_chk(int'(TBL[k].rq), TBL[k].a, TBL[k].d);
        default: ev(TBL[k].a, TBL[k].d[2:0]);
      endcase
    end

    // R14: reset clears everything
    do_reset();
    rd_chk(14, 3'd7, 8'h00);
    rd_chk(14, 3'd0, 8'h00);
    rd_chk(14, 3'd6, 8'h00);
    rd_chk(14, 3'd4, 8'h00);
    rd_chk(14, 3'd1, 8'h00);
    check(14, "irq after reset", {7'd0, ep_irq}, 8'h00);

    // R13: flags without enables give no request
    ev(3'd2, 3'd1);
    check(13, "irq enables off", {7'd0, ep_irq}, 8'h00);
    check(2, "summary ep2", {3'd0, ep_summary}, 8'h04);
    wr(3'd0, 8'h02);
    wr(3'd5, 8'h04);
    check(13, "irq out enabled", {7'd0, ep_irq}, 8'h01);
    wr(3'd5, 8'h00);
    check(13, "irq disabled again", {7'd0, ep_irq}, 8'h00);
    ev(3'd2, 3'd3);
    check(3, "irq overflow without enable", {7'd0, ep_irq}, 8'h00);
    wr(3'd5, 8'h10);
    check(3, "irq flow-error enabled", {7'd0, ep_irq}, 8'h01);
    wr(3'd5, 8'h00);

    // R7: read/write-allowed follows FIFO state and direction
    sel_fifo_empty = 1'b0;
    rd_chk(7, 3'd6, 8'h24);
    sel_fifo_empty = 1'b1;
    rd_chk(7, 3'd6, 8'h04);
    wr(3'd2, 8'h81);
    sel_fifo_full = 1'b1;
    rd_chk(7, 3'd6, 8'h04);
    sel_fifo_full = 1'b0;
    rd_chk(7, 3'd6, 8'h24);

    // R12: stalled endpoint answered with stall, flag on endpoint 0
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h20);
    @(negedge clk);
    host_acc_valid = 1'b1; host_acc_ep = 3'd2;
    #1;
    check(12, "no stall on ep2", {7'd0, host_stall}, 8'h00);
    host_acc_ep = 3'd3;
    #1;
    check(12, "stall on ep3", {7'd0, host_stall}, 8'h01);
    @(negedge clk);
    host_acc_valid = 1'b0;
    wr(3'd0, 8'h00);
    sel_fifo_empty = 1'b1;
    rd_chk(12, 3'd6, 8'h02);
    rd_chk(12, 3'd7, 8'h05);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule